// File: doc/BRIEF.md
# Two-Rate Sample Capture Sequencer

This block paces a 16-bit successive-approximation converter that hands its result over an 8-bit port, one byte at a time. It stores a record of fixed length into a byte-wide static memory. A start command does four things in order. It latches the rate-select bit. It fires one coil of a latching relay that picks the matching anti-alias path. It waits for the relay to settle. It then converts at a fixed period, either the slow rate (10 kHz at 40 MHz) or the fast rate (100 kHz).

Each sample is written as two bytes in big-endian order. The high byte goes to the even address and the low byte to the odd address that follows it. After the last sample the block shows a finished indication. It keeps that indication until the host reports that the memory has been read out. A two-colour indicator shows three conditions: idle, capturing and finished.

Top module: `adc_capture_seq`

## Requirements
- R1: While reset is held, the outputs are at rest. The convert strobe, write strobe and memory select are high (inactive). Both coil outputs are low, the address is 0 and the indicator is green only.
- R2: A start seen while idle latches `rate_sel`. The block then drives `coil_fast` (rate 1) or `coil_slow` (rate 0) high for exactly COIL_CYC cycles. The other coil stays low, and the two coils are never high together.
- R3: Sampling waits for a settling time after the coil pulse. The first convert strobe falls exactly COIL_CYC+SETTLE_CYC+DIV+1 cycles after the edge that accepts start. DIV is DIV_FAST for rate 1 and DIV_SLOW for rate 0.
- R4: Within a record, consecutive falling edges of `adc_conv_n` are exactly DIV cycles apart, whatever the converter latency. Each strobe is low for CONV_CYC cycles, and it only falls while `adc_ready` is high.
- R5: Converter data is only taken after `adc_ready` has gone low and then high again. Bytes presented while the converter is busy are never stored.
- R6: `adc_byte_lo` = 0 selects the high byte and 1 selects the low byte. For sample k, the high byte is stored at address 2k and the low byte at address 2k+1, including the two's-complement extremes 8000h and 7FFFh.
- R7: Each write drops `sram_we_n` for WE_CYC cycles, with `sram_ce_n` low. Address and data stay stable while it is low. The address only changes when the write strobe is high and was high in the cycle before.
- R8: A record is exactly NUM_SAMPLES conversions and 2*NUM_SAMPLES byte writes. After that the block enters the finished state.
- R9: The indicator shows green only when idle, green and red together while capturing (relay, settle and sampling), and red only when finished.
- R10: A start during capture or in the finished state has no effect. The finished state holds until a `record_drained` pulse returns the block to idle.
- R11: A change of `rate_sel` after start has no effect on the running record's period or relay choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel | input | 1 | 0 = slow rate, 1 = fast rate; latched at start |
| start_req | input | 1 | Start a record (acted on only when idle) |
| record_drained | input | 1 | Host has read the record; leave the finished state |
| adc_ready | input | 1 | Converter idle / result valid (low while converting) |
| adc_data | input | 8 | Byte of the converter result chosen by `adc_byte_lo` |
| adc_conv_n | output | 1 | Convert strobe, active low |
| adc_byte_lo | output | 1 | 0 = present high byte, 1 = present low byte |
| sram_addr | output | ADDR_W | Memory byte address |
| sram_din | output | 8 | Memory write data |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_ce_n | output | 1 | Memory select, active low |
| coil_fast | output | 1 | Relay coil pulse selecting the fast-rate filter |
| coil_slow | output | 1 | Relay coil pulse selecting the slow-rate filter |
| led_green | output | 1 | Green half of the status indicator |
| led_red | output | 1 | Red half of the status indicator |

## Verification
The converter model shows a fixed garbage byte while busy and has a random latency. A sequencer that reads early, or one that swaps the byte order, stores values that do not match the bench's log of sample values. The first two samples are the two's-complement extremes, so a byte swap cannot hide. The spacing between convert strobes is measured against DIV. A timer restarted by the handshake would stretch every period by the converter latency. A skipped settle delay would move the first strobe. The bench also sends a start and a rate change in the middle of a record and again in the finished state. A design that re-armed or re-latched the rate would fire a second coil pulse, change the period or leave the finished state.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [3:0] {
    ST_READY,
    ST_RELAY,
    ST_WAIT_TICK,
    ST_CONV,
    ST_BUSY,
    ST_WR_HI,
    ST_GAP_HI,
    ST_WR_LO,
    ST_GAP_LO,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    RL_IDLE,
    RL_PULSE,
    RL_SETTLE
  } relay_phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_cap_tick.sv
module adc_cap_tick
  import adc_cap_pkg::*;
#(
  parameter int DIV_SLOW = 4000,
  parameter int DIV_FAST = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic tick
);
  localparam int CW = $clog2(max2(DIV_SLOW, DIV_FAST));
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  assign lim  = fast ? LIM_FAST : LIM_SLOW;
  assign tick = en && (cnt_q == lim);

  // free-running while enabled; the handshake never restarts it
  always_comb begin
    if (!en)                cnt_d = '0;
    else if (cnt_q == lim)  cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_cap_relay.sv
module adc_cap_relay
  import adc_cap_pkg::*;
#(
  parameter int COIL_CYC   = 400,
  parameter int SETTLE_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic want_fast,
  output logic coil_fast,
  output logic coil_slow,
  output logic settled
);
  localparam int CW = $clog2(max2(COIL_CYC, SETTLE_CYC) + 1);
  localparam logic [CW-1:0] COIL_LAST   = CW'(COIL_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  relay_phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic fast_q, fast_d, slow_q, slow_d, done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    fast_d  = fast_q;
    slow_d  = slow_q;
    done_d  = 1'b0;
    case (phase_q)
      RL_IDLE: begin
        if (go) begin
          phase_d = RL_PULSE;
          cnt_d   = '0;
          fast_d  = want_fast;
          slow_d  = !want_fast;
        end
      end
      RL_PULSE: begin
        if (cnt_q == COIL_LAST) begin
          phase_d = RL_SETTLE;
          cnt_d   = '0;
          fast_d  = 1'b0;
          slow_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RL_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          phase_d = RL_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: phase_d = RL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= RL_IDLE;
      cnt_q   <= '0;
      fast_q  <= 1'b0;
      slow_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      fast_q  <= fast_d;
      slow_q  <= slow_d;
      done_q  <= done_d;
    end
  end

  assign coil_fast = fast_q;
  assign coil_slow = slow_q;
  assign settled   = done_q;
endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_cap_pkg::*;
#(
  parameter int NUM_SAMPLES = 8192,
  parameter int ADDR_W      = 15,
  parameter int DIV_SLOW    = 4000,
  parameter int DIV_FAST    = 400,
  parameter int COIL_CYC    = 400,
  parameter int SETTLE_CYC  = 40000,
  parameter int CONV_CYC    = 2,
  parameter int WE_CYC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_sel,
  input  logic              start_req,
  input  logic              record_drained,
  input  logic              adc_ready,
  input  logic [7:0]        adc_data,
  output logic              adc_conv_n,
  output logic              adc_byte_lo,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [7:0]        sram_din,
  output logic              sram_we_n,
  output logic              sram_ce_n,
  output logic              coil_fast,
  output logic              coil_slow,
  output logic              led_green,
  output logic              led_red
);
  localparam int SMP_W = $clog2(NUM_SAMPLES);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(NUM_SAMPLES - 1);
  localparam int CYC_W = $clog2(max2(CONV_CYC, WE_CYC) + 1);
  localparam logic [CYC_W-1:0] CONV_LAST = CYC_W'(CONV_CYC - 1);
  localparam logic [CYC_W-1:0] WE_LAST   = CYC_W'(WE_CYC);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  seq_state_e        state_q, state_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SMP_W-1:0]  smp_q, smp_d;
  logic [7:0]        dreg_q, dreg_d;
  logic              rate_q, rate_d;
  logic              seen_q, seen_d;
  logic              relay_go, relay_done, tick, tick_en;

  logic conv_n_q, byte_lo_q, we_n_q, ce_n_q, green_q, red_q;
  logic conv_n_d, byte_lo_d, we_n_d, ce_n_d, green_d, red_d;

  assign tick_en = state_q inside {ST_WAIT_TICK, ST_CONV, ST_BUSY, ST_WR_HI,
                                   ST_GAP_HI, ST_WR_LO, ST_GAP_LO};

  adc_cap_tick #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .en(tick_en), .fast(rate_q), .tick(tick)
  );

  adc_cap_relay #(.COIL_CYC(COIL_CYC), .SETTLE_CYC(SETTLE_CYC)) u_relay (
    .clk(clk), .rst_n(rst_i_n), .go(relay_go), .want_fast(rate_d),
    .coil_fast(coil_fast), .coil_slow(coil_slow), .settled(relay_done)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cyc_d    = cyc_q;
    addr_d   = addr_q;
    smp_d    = smp_q;
    dreg_d   = dreg_q;
    rate_d   = rate_q;
    seen_d   = seen_q;
    relay_go = 1'b0;
    if ((state_q == ST_CONV || state_q == ST_BUSY) && !adc_ready) seen_d = 1'b1;
    case (state_q)
      ST_READY: begin
        if (start_req) begin
          rate_d   = rate_sel;
          relay_go = 1'b1;
          addr_d   = '0;
          smp_d    = '0;
          state_d  = ST_RELAY;
        end
      end
      ST_RELAY: if (relay_done) state_d = ST_WAIT_TICK;
      ST_WAIT_TICK: begin
        seen_d = 1'b0;
        if (tick) begin
          cyc_d   = '0;
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        if (cyc_q == CONV_LAST) state_d = ST_BUSY;
        else                    cyc_d   = cyc_q + 1'b1;
      end
      ST_BUSY: begin
        if (adc_ready && seen_q) begin
          dreg_d  = adc_data;
          cyc_d   = '0;
          state_d = ST_WR_HI;
        end
      end
      ST_WR_HI: begin
        if (cyc_q == WE_LAST) state_d = ST_GAP_HI;
        else                  cyc_d   = cyc_q + 1'b1;
      end
      ST_GAP_HI: begin
        dreg_d  = adc_data;
        addr_d  = addr_q + 1'b1;
        cyc_d   = '0;
        state_d = ST_WR_LO;
      end
      ST_WR_LO: begin
        if (cyc_q == WE_LAST) state_d = ST_GAP_LO;
        else                  cyc_d   = cyc_q + 1'b1;
      end
      ST_GAP_LO: begin
        addr_d  = addr_q + 1'b1;
        smp_d   = smp_q + 1'b1;
        state_d = (smp_q == SMP_LAST) ? ST_DONE : ST_WAIT_TICK;
      end
      ST_DONE: if (record_drained) state_d = ST_READY;
      default: state_d = ST_READY;
    endcase
  end

  // outputs decoded from the next state so that they leave a flop
  always_comb begin
    conv_n_d  = (state_d != ST_CONV);
    we_n_d    = !((state_d inside {ST_WR_HI, ST_WR_LO}) && (cyc_d != '0));
    ce_n_d    = !(state_d inside {ST_WR_HI, ST_GAP_HI, ST_WR_LO, ST_GAP_LO});
    byte_lo_d = state_d inside {ST_GAP_HI, ST_WR_LO, ST_GAP_LO};
    green_d   = (state_d != ST_DONE);
    red_d     = (state_d != ST_READY);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_READY;
      cyc_q     <= '0;
      addr_q    <= '0;
      smp_q     <= '0;
      dreg_q    <= '0;
      rate_q    <= 1'b0;
      seen_q    <= 1'b0;
      conv_n_q  <= 1'b1;
      byte_lo_q <= 1'b0;
      we_n_q    <= 1'b1;
      ce_n_q    <= 1'b1;
      green_q   <= 1'b1;
      red_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cyc_q     <= cyc_d;
      addr_q    <= addr_d;
      smp_q     <= smp_d;
      dreg_q    <= dreg_d;
      rate_q    <= rate_d;
      seen_q    <= seen_d;
      conv_n_q  <= conv_n_d;
      byte_lo_q <= byte_lo_d;
      we_n_q    <= we_n_d;
      ce_n_q    <= ce_n_d;
      green_q   <= green_d;
      red_q     <= red_d;
    end
  end

  assign adc_conv_n  = conv_n_q;
  assign adc_byte_lo = byte_lo_q;
  assign sram_addr   = addr_q;
  assign sram_din    = dreg_q;
  assign sram_we_n   = we_n_q;
  assign sram_ce_n   = ce_n_q;
  assign led_green   = green_q;
  assign led_red     = red_q;
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_ready,
  input logic              adc_conv_n,
  input logic              adc_byte_lo,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [7:0]        sram_din,
  input logic              sram_we_n,
  input logic              sram_ce_n,
  input logic              coil_fast,
  input logic              coil_slow,
  input logic              led_green,
  input logic              led_red
);
  p_coil_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(coil_fast && coil_slow));

  p_conv_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv_n) |-> adc_ready);

  p_byte_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |-> $stable(adc_byte_lo));

  p_we_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  p_we_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |=> !sram_we_n);

  p_we_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_din)));

  p_addr_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n)));

  p_led_lit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    led_green || led_red);
endmodule

bind adc_capture_seq adc_capture_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .adc_ready(adc_ready), .adc_conv_n(adc_conv_n),
  .adc_byte_lo(adc_byte_lo), .sram_addr(sram_addr), .sram_din(sram_din),
  .sram_we_n(sram_we_n), .sram_ce_n(sram_ce_n), .coil_fast(coil_fast),
  .coil_slow(coil_slow), .led_green(led_green), .led_red(led_red)
);

// File: tb/test_adc_capture_seq.sv
module test_adc_capture_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_SMP  = 8;
  localparam int AW     = 15;
  localparam int D_SLOW = 100;
  localparam int D_FAST = 40;
  localparam int COIL   = 5;
  localparam int SETTLE = 12;
  localparam int CONV   = 2;
  localparam int WE     = 2;

  logic clk = 1'b0;
  logic rst_n, rate_sel, start_req, record_drained;
  logic adc_ready;
  logic [7:0] adc_data;
  logic adc_conv_n, adc_byte_lo, sram_we_n, sram_ce_n;
  logic coil_fast, coil_slow, led_green, led_red;
  logic [AW-1:0] sram_addr;
  logic [7:0] sram_din;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_capture_seq #(
    .NUM_SAMPLES(N_SMP), .ADDR_W(AW), .DIV_SLOW(D_SLOW), .DIV_FAST(D_FAST),
    .COIL_CYC(COIL), .SETTLE_CYC(SETTLE), .CONV_CYC(CONV), .WE_CYC(WE)
  ) i_adc_capture_seq (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .start_req(start_req),
    .record_drained(record_drained), .adc_ready(adc_ready), .adc_data(adc_data),
    .adc_conv_n(adc_conv_n), .adc_byte_lo(adc_byte_lo), .sram_addr(sram_addr),
    .sram_din(sram_din), .sram_we_n(sram_we_n), .sram_ce_n(sram_ce_n),
    .coil_fast(coil_fast), .coil_slow(coil_slow), .led_green(led_green),
    .led_red(led_red)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural converter: random latency, garbage byte while busy
  logic        mdl_ready;
  logic [15:0] mdl_res, draw;
  int          mdl_lat, mdl_idx;
  logic [15:0] smp_log [0:63];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_ready <= 1'b1;
      mdl_res   <= 16'h0;
      mdl_lat   <= 0;
      mdl_idx   <= 0;
    end else if (mdl_ready && !adc_conv_n) begin
      if (mdl_idx == 0)      draw = 16'h8000;
      else if (mdl_idx == 1) draw = 16'h7FFF;
      else                   draw = 16'($urandom);
      mdl_ready <= 1'b0;
      mdl_res   <= draw;
      mdl_lat   <= 3 + int'($urandom % 6);
      if (mdl_idx < 64) smp_log[mdl_idx] <= draw;
      mdl_idx   <= mdl_idx + 1;
    end else if (!mdl_ready) begin
      if (mdl_lat == 0) mdl_ready <= 1'b1;
      else              mdl_lat   <= mdl_lat - 1;
    end
  end
  assign adc_ready = mdl_ready;
  assign adc_data  = !mdl_ready ? 8'hA5 : (adc_byte_lo ? mdl_res[7:0] : mdl_res[15:8]);

  // port monitor
  logic clear_mon = 1'b1;
  int   exp_div = D_FAST;
  logic [7:0] mem [0:63];
  int wr_cnt, conv_cnt, bad_stable, bad_we_len, bad_ce, bad_period, bad_conv_len;
  int bad_conv_busy, bad_addr, bad_both, fast_len, slow_len, first_conv, last_conv;
  int we_len, conv_len;
  logic [AW-1:0] hold_addr;
  logic [7:0] hold_din;
  logic prev_we, prev_conv;

  always @(negedge clk) begin
    if (clear_mon) begin
      wr_cnt = 0; conv_cnt = 0; bad_stable = 0; bad_we_len = 0; bad_ce = 0;
      bad_period = 0; bad_conv_len = 0; bad_conv_busy = 0; bad_addr = 0;
      bad_both = 0; fast_len = 0; slow_len = 0; first_conv = 0; last_conv = 0;
      we_len = 0; conv_len = 0; prev_we = 1'b1; prev_conv = 1'b1;
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    end else if (rst_n) begin
      if (!sram_we_n) begin
        if (sram_ce_n) bad_ce++;
        if (prev_we) begin
          wr_cnt++; we_len = 1; hold_addr = sram_addr; hold_din = sram_din;
          if (sram_addr < AW'(64)) mem[int'(sram_addr)] = sram_din;
          else bad_addr++;
        end else begin
          we_len++;
          if (sram_addr != hold_addr || sram_din != hold_din) bad_stable++;
        end
      end else if (!prev_we && we_len < WE) bad_we_len++;
      prev_we = sram_we_n;
      if (!adc_conv_n) begin
        if (prev_conv) begin
          conv_cnt++;
          if (!mdl_ready) bad_conv_busy++;
          if (conv_cnt == 1) first_conv = cyc;
          else if (cyc - last_conv != exp_div) bad_period++;
          last_conv = cyc; conv_len = 1;
        end else conv_len++;
      end else if (!prev_conv && conv_len != CONV) bad_conv_len++;
      prev_conv = adc_conv_n;
      if (coil_fast) fast_len++;
      if (coil_slow) slow_len++;
      if (coil_fast && coil_slow) bad_both++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_capture(input bit rate, input bit disturb);
    int base, start_cyc, bad_bytes, waited;
    bit leds_seen, poked;
    clear_mon = 1'b1;
    @(negedge clk);
    clear_mon = 1'b0;
    base = mdl_idx;
    exp_div = rate ? D_FAST : D_SLOW;
    rate_sel = rate;
    start_req = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start_req = 1'b0;
    leds_seen = 1'b0; poked = 1'b0; waited = 0;
    while (!(led_red && !led_green) && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (conv_cnt == 2 && !leds_seen) begin
        leds_seen = 1'b1;
        check(led_green && led_red, "R9 capturing shows both colours",
              {led_green, led_red}, 3);
      end
      if (disturb && conv_cnt == 3 && !poked) begin
        poked = 1'b1;
        rate_sel = !rate;   // R11 stimulus
        start_req = 1'b1;   // R10 stimulus
        @(negedge clk);
        start_req = 1'b0;
      end
    end
    check(waited < 20000, "R8 record finishes", waited, 0);
    check(conv_cnt == N_SMP, "R8 conversion count", conv_cnt, N_SMP);
    check(wr_cnt == 2 * N_SMP, "R8 byte write count", wr_cnt, 2 * N_SMP);
    bad_bytes = 0;
    for (int k = 0; k < N_SMP; k++) begin
      if (mem[2 * k] != smp_log[base + k][15:8]) bad_bytes++;
      if (mem[2 * k + 1] != smp_log[base + k][7:0]) bad_bytes++;
    end
    check(bad_bytes == 0, "R6 R5 big-endian stored bytes", bad_bytes, 0);
    check(mem[1] == smp_log[base][7:0], "R6 low byte at odd address",
          int'(mem[1]), int'(smp_log[base][7:0]));
    check(bad_addr == 0, "R6 addresses inside record", bad_addr, 0);
    check(bad_stable == 0, "R7 address/data stable under strobe", bad_stable, 0);
    check(bad_we_len == 0, "R7 strobe width", bad_we_len, 0);
    check(bad_ce == 0, "R7 select low with strobe", bad_ce, 0);
    check(bad_period == 0, disturb ? "R11 period kept after rate change" : "R4 conversion period",
          bad_period, 0);
    check(bad_conv_len == 0, "R4 convert strobe width", bad_conv_len, 0);
    check(bad_conv_busy == 0, "R4 strobe only when ready", bad_conv_busy, 0);
    check(first_conv - start_cyc == COIL + SETTLE + exp_div + 2,
          "R3 settle before first conversion", first_conv - start_cyc,
          COIL + SETTLE + exp_div + 2);
    check((rate ? fast_len : slow_len) == COIL, "R2 chosen coil pulse length",
          rate ? fast_len : slow_len, COIL);
    check((rate ? slow_len : fast_len) == 0, disturb ? "R11 R2 other coil idle" : "R2 other coil idle",
          rate ? slow_len : fast_len, 0);
    check(bad_both == 0, "R2 coils exclusive", bad_both, 0);
    check(led_red && !led_green, "R9 finished shows red only", {led_green, led_red}, 1);
    // finished state persists and ignores start
    repeat (20) @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (COIL + SETTLE + exp_div + 10) @(negedge clk);
    check(led_red && !led_green, "R10 finished held, start ignored", {led_green, led_red}, 1);
    check(conv_cnt == N_SMP && fast_len + slow_len == COIL,
          "R10 no conversion or coil after start in finished", conv_cnt, N_SMP);
    record_drained = 1'b1;
    @(negedge clk);
    record_drained = 1'b0;
    @(negedge clk);
    check(led_green && !led_red, "R10 R9 drained returns to ready", {led_green, led_red}, 2);
  endtask

  initial begin
    int seed_set;
    seed_set = int'($urandom(32'd2024));
    rst_n = 1'b0; rate_sel = 1'b0; start_req = 1'b0; record_drained = 1'b0;
    repeat (3) @(negedge clk);
    check(adc_conv_n && sram_we_n && sram_ce_n, "R1 strobes inactive in reset",
          {adc_conv_n, sram_we_n, sram_ce_n}, 7);
    check(!coil_fast && !coil_slow, "R1 coils low in reset", {coil_fast, coil_slow}, 0);
    check(sram_addr == '0, "R1 address zero in reset", int'(sram_addr), 0);
    check(led_green && !led_red, "R1 ready indication in reset", {led_green, led_red}, 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_capture(1'b1, 1'b0);
    run_capture(1'b0, 1'b0);
    run_capture(1'b1, 1'b1);
    run_capture(1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule